// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a single-cycle register-transfer engine. Each clock cycle a packed 16-bit control word names two source registers, a destination register, an operation and two routing choices. The block reads the sources combinationally, runs the chosen operation, and writes the result into the destination on the next rising edge. Eight general registers of a configurable width (8 bits by default) live inside.

A second operand can come from an external constant instead of a register. Write-back can take external data instead of the operation result. The first operand bus leaves the block as an address output and the second operand bus as a data output, so a surrounding sequencer can reach memory. Four status flags describe the current operation result. The block does no fetching and no sequencing: whoever drives the control word decides what happens each cycle.

Top module: `cw_datapath`

## Requirements
- R1: The control word holds the destination select in bits 15:13, the first source select in bits 12:10, the second source select in bits 9:7, the operand-B routing bit in bit 6, the function code in bits 5:2, the write-back routing bit in bit 1 and the write strobe in bit 0. A 3-bit select value k addresses register Rk. `addrOut` always shows the first source register and, with bit 6 clear, `dataOut` shows the second source register.
- R2: With bit 6 set, `constIn` replaces the second source register on the B operand bus, both at `dataOut` and as the operand of the function unit.
- R3: With bit 1 clear the function result is written back. With bit 1 set `dataIn` is written back instead. The write lands in the destination register at the rising clock edge.
- R4: With bit 0 clear no register changes, whatever the other fields hold.
- R5: A synchronous active-high `rst` clears all eight registers to zero at the next rising edge.
- R6: Reads are combinational. In a cycle that writes a register and also reads it, the read shows the value from before the write, and the new value appears from the next cycle on.
- R7: Function codes 0000 to 0111 compute A + Y + c, where c is the lowest code bit and Y is selected by code bits 2:1: 00 gives zero, 01 gives B, 10 gives the inverse of B, and 11 gives all ones. The results are A, A+1, A+B, A+B+1, A+~B, A−B, A−1 and A.
- R8: Function codes 1000, 1001, 1010 and 1011 give A AND B, A OR B, A XOR B and NOT A.
- R9: Function codes 1100 and 1111 pass B. Code 1101 shifts B right by one with a zero fill at the top, and code 1110 shifts B left by one with a zero fill at the bottom. The shifted operand comes from the B bus, so it is named by bits 9:7.
- R10: `flagZ` is set when the result is zero and `flagN` equals the result's top bit. For codes below 1000, `flagC` is the carry out of A + Y + c, and `flagV` is set when A and Y have the same sign and the result's sign differs from it. For all other codes, C and V are zero.
- R11: Each control word completes its whole transfer in one clock cycle, so a run of back-to-back words leaves the registers exactly as applying them one after another would.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the register file |
| ctrlWord | input | 16 | Control word applied for this cycle |
| constIn | input | DATA_W | External constant for the B operand bus |
| dataIn | input | DATA_W | External data for write-back |
| addrOut | output | DATA_W | A operand bus |
| dataOut | output | DATA_W | B operand bus |
| flagV | output | 1 | Signed overflow of the current result |
| flagC | output | 1 | Carry out of the current result |
| flagN | output | 1 | Sign of the current result |
| flagZ | output | 1 | Current result is zero |

## Verification
The hardest case to reach from the ports is a word that reads and writes the same register in one cycle. Only then can a bypass or a one-cycle write delay be told apart from the intended old-value read. The bench issues words whose three selects all name the same register with an increment. It checks `addrOut` before the edge against the old value, then reads the register back on the following cycle. The function unit can only be seen by writing its result to a spare register, so every code is swept with operand pairs chosen to hit carry, overflow and zero.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;

  localparam int CW_W     = 16;
  localparam int SEL_W    = 3;
  localparam int FN_W     = 4;
  localparam int NUM_REGS = 1 << SEL_W;

  // field positions within the control word
  localparam int DST_LSB  = 13;
  localparam int ASEL_LSB = 10;
  localparam int BSEL_LSB = 7;
  localparam int KSRC_BIT = 6;
  localparam int FN_LSB   = 2;
  localparam int WSRC_BIT = 1;
  localparam int WEN_BIT  = 0;

  typedef enum logic [FN_W-1:0] {
    FN_PASSA  = 4'b0000,
    FN_INC    = 4'b0001,
    FN_ADD    = 4'b0010,
    FN_ADDC   = 4'b0011,
    FN_ADDNB  = 4'b0100,
    FN_SUB    = 4'b0101,
    FN_DEC    = 4'b0110,
    FN_PASSA2 = 4'b0111,
    FN_AND    = 4'b1000,
    FN_OR     = 4'b1001,
    FN_XOR    = 4'b1010,
    FN_NOTA   = 4'b1011,
    FN_PASSB  = 4'b1100,
    FN_SHR    = 4'b1101,
    FN_SHL    = 4'b1110,
    FN_PASSB2 = 4'b1111
  } fnCode_e;

  typedef struct packed {
    logic [SEL_W-1:0] dstSel;
    logic [SEL_W-1:0] aSel;
    logic [SEL_W-1:0] bSel;
    logic             constOnB;
    fnCode_e          fnSel;
    logic             takeDataIn;
    logic             wrEn;
  } ctrlStrobes_t;

endpackage

// File: rtl/cw_decoder.sv
module cw_decoder
  import cwdp_pkg::*;
(
  input  logic [CW_W-1:0] ctrlWord,
  output ctrlStrobes_t    strobes
);

  always_comb begin
    strobes.dstSel     = ctrlWord[DST_LSB  +: SEL_W];
    strobes.aSel       = ctrlWord[ASEL_LSB +: SEL_W];
    strobes.bSel       = ctrlWord[BSEL_LSB +: SEL_W];
    strobes.constOnB   = ctrlWord[KSRC_BIT];
    strobes.fnSel      = fnCode_e'(ctrlWord[FN_LSB +: FN_W]);
    strobes.takeDataIn = ctrlWord[WSRC_BIT];
    strobes.wrEn       = ctrlWord[WEN_BIT];
  end

endmodule

// File: rtl/cw_regfile.sv
module cw_regfile
  import cwdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  rdAddrA,
  input  logic [SEL_W-1:0]  rdAddrB,
  input  logic [SEL_W-1:0]  wrAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  // one load-enabled register per slot
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= '0;
      end else if (wrEn && (wrAddr == SEL_W'(i))) begin
        regs[i] <= wrData;
      end
    end
  end

  // combinational reads see the stored value, never the incoming write
  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> (regs[$past(wrAddr)] == $past(wrData)));

  // R4
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(regs));

  // R5
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (regs == '0));

endmodule

// File: rtl/cw_funcunit.sv
module cw_funcunit
  import cwdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  fnCode_e           fnSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              flagV,
  output logic              flagC,
  output logic              flagN,
  output logic              flagZ
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] yOperand;
  logic              carryIn;
  logic [DATA_W:0]   sumExt;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] shiftRes;
  logic              isArith;
  logic              isShiftGrp;

  assign isArith    = ~fnSel[3];
  assign isShiftGrp = fnSel[3] & fnSel[2];
  assign carryIn    = fnSel[0];

  // adder B-side selection
  always_comb begin
    unique case (fnSel[2:1])
      2'b00:   yOperand = '0;
      2'b01:   yOperand = opB;
      2'b10:   yOperand = ~opB;
      default: yOperand = '1;
    endcase
  end

  assign sumExt = {1'b0, opA} + {1'b0, yOperand} + {{DATA_W{1'b0}}, carryIn};

  // bitwise logic slice
  for (genvar i = 0; i < DATA_W; i++) begin : g_logicBit
    always_comb begin
      unique case (fnSel[1:0])
        2'b00:   logicRes[i] = opA[i] & opB[i];
        2'b01:   logicRes[i] = opA[i] | opB[i];
        2'b10:   logicRes[i] = opA[i] ^ opB[i];
        default: logicRes[i] = ~opA[i];
      endcase
    end
  end

  // single-position shifter on the B operand
  always_comb begin
    unique case (fnSel[1:0])
      2'b01:   shiftRes = {1'b0, opB[MSB:1]};
      2'b10:   shiftRes = {opB[MSB-1:0], 1'b0};
      default: shiftRes = opB;
    endcase
  end

  always_comb begin
    if (isArith)         result = sumExt[DATA_W-1:0];
    else if (isShiftGrp) result = shiftRes;
    else                 result = logicRes;
  end

  assign flagC = isArith & sumExt[DATA_W];
  assign flagV = isArith & (opA[MSB] == yOperand[MSB]) & (result[MSB] != opA[MSB]);
  assign flagN = result[MSB];
  assign flagZ = (result == '0);

endmodule

// File: rtl/cw_path.sv
module cw_path
  import cwdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] constIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] busA,
  output logic [DATA_W-1:0] busB,
  output logic              flagV,
  output logic              flagC,
  output logic              flagN,
  output logic              flagZ
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] regA;
  logic [DATA_W-1:0] regB;
  logic [DATA_W-1:0] fuOut;
  logic [DATA_W-1:0] busD;

  cw_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (strobes.aSel),
    .rdAddrB (strobes.bSel),
    .wrAddr  (strobes.dstSel),
    .wrEn    (strobes.wrEn),
    .wrData  (busD),
    .rdDataA (regA),
    .rdDataB (regB)
  );

  assign busA = regA;
  assign busB = strobes.constOnB ? constIn : regB;

  cw_funcunit #(.DATA_W(DATA_W)) u_fu (
    .fnSel  (strobes.fnSel),
    .opA    (busA),
    .opB    (busB),
    .result (fuOut),
    .flagV  (flagV),
    .flagC  (flagC),
    .flagN  (flagN),
    .flagZ  (flagZ)
  );

  assign busD = strobes.takeDataIn ? dataIn : fuOut;

  // R7
  add_result_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.fnSel == FN_ADD) |-> (fuOut == DATA_W'(busA + busB)));

  // R9
  shr_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.fnSel == FN_SHR) |-> (fuOut[MSB] == 1'b0));

  // R10
  zero_not_neg_chk: assert property (@(posedge clk) disable iff (rst)
    flagZ |-> !flagN);

endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
  import cwdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW_W-1:0]   ctrlWord,
  input  logic [DATA_W-1:0] constIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              flagV,
  output logic              flagC,
  output logic              flagN,
  output logic              flagZ
);

  ctrlStrobes_t strobes;

  cw_decoder u_dec (
    .ctrlWord (ctrlWord),
    .strobes  (strobes)
  );

  cw_path #(.DATA_W(DATA_W)) u_path (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .constIn (constIn),
    .dataIn  (dataIn),
    .busA    (addrOut),
    .busB    (dataOut),
    .flagV   (flagV),
    .flagC   (flagC),
    .flagN   (flagN),
    .flagZ   (flagZ)
  );

endmodule

// File: tb/cw_datapath_tb.sv
module cw_datapath_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  ctrlWord = '0;
  logic [W-1:0] constIn = '0;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] addrOut;
  logic [W-1:0] dataOut;
  logic         flagV, flagC, flagN, flagZ;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [W-1:0] model [8];
  logic [W-1:0] text [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cw_datapath #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .ctrlWord(ctrlWord), .constIn(constIn), .dataIn(dataIn),
    .addrOut(addrOut), .dataOut(dataOut),
    .flagV(flagV), .flagC(flagC), .flagN(flagN), .flagZ(flagZ)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mkCw(input logic [2:0] da, input logic [2:0] aa, input logic [2:0] ba,
                                       input logic mb, input logic [3:0] fs, input logic md, input logic rw);
    return {da, aa, ba, mb, fs, md, rw};
  endfunction

  // reference result: {V, C, N, Z, F}, written from the requirement text
  function automatic logic [W+3:0] refFn(input logic [3:0] fs, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0]   s;
    logic [W-1:0] y;
    logic [W-1:0] f;
    logic v, c;
    v = 0; c = 0; y = '0; s = '0;
    if (fs < 4'd8) begin
      case (fs)
        4'd0: begin y = 8'h00; s = a; end
        4'd1: begin y = 8'h00; s = a + 9'd1; end
        4'd2: begin y = b;     s = a + b; end
        4'd3: begin y = b;     s = a + b + 9'd1; end
        4'd4: begin y = ~b;    s = a + {1'b0, ~b}; end
        4'd5: begin y = ~b;    s = a + {1'b0, ~b} + 9'd1; end
        4'd6: begin y = 8'hFF; s = a + 9'hFF; end
        default: begin y = 8'hFF; s = a + 9'h100; end
      endcase
      f = s[W-1:0];
      c = s[W];
      v = (a[W-1] == y[W-1]) && (f[W-1] != a[W-1]);
    end else begin
      case (fs)
        4'd8:  f = a & b;
        4'd9:  f = a | b;
        4'd10: f = a ^ b;
        4'd11: f = ~a;
        4'd13: f = b >> 1;
        4'd14: f = b << 1;
        default: f = b;
      endcase
    end
    return {v, c, f[W-1], (f == 0), f};
  endfunction

  function automatic string fnReq(input logic [3:0] fs);
    if (fs < 4'd8) return "R7";
    if (fs < 4'd12) return "R8";
    return "R9";
  endfunction

  // apply one word: check the buses and flags before the edge, then update the model
  task automatic doWord(input string req, input logic [15:0] cw, input logic [W-1:0] k, input logic [W-1:0] d);
    logic [2:0] da, aa, ba;
    logic [3:0] fs;
    logic [W-1:0] bv;
    logic [W+3:0] r;
    da = cw[15:13]; aa = cw[12:10]; ba = cw[9:7]; fs = cw[5:2];
    @(negedge clk);
    ctrlWord = cw; constIn = k; dataIn = d;
    #1;
    bv = cw[6] ? k : model[ba];
    r  = refFn(fs, model[aa], bv);
    chk(req, "addrOut", addrOut, model[aa]);
    chk(req, "dataOut", dataOut, bv);
    chk("R10", "flags", {flagV, flagC, flagN, flagZ}, r[W+3:W]);
    @(posedge clk);
    if (cw[0]) model[da] = cw[1] ? d : r[W-1:0];
    #1;
  endtask

  task automatic readReg(input logic [2:0] k, output logic [W-1:0] val);
    @(negedge clk);
    ctrlWord = mkCw(3'd0, k, k, 1'b0, 4'b0000, 1'b0, 1'b0);
    #1 val = addrOut;
  endtask

  task automatic checkAll(input string req);
    logic [W-1:0] v;
    for (int k = 0; k < 8; k++) begin
      readReg(3'(k), v);
      chk(req, $sformatf("R%0d", k), v, model[k]);
    end
  endtask

  task automatic loadText();
    for (int k = 0; k < 8; k++)
      doWord("R3", mkCw(3'(k), 3'd0, 3'd0, 1'b0, 4'b0000, 1'b1, 1'b1), 8'h00, text[k]);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    for (int k = 0; k < 8; k++) model[k] = '0;
    checkAll("R5");
  endtask

  task automatic t_load();
    loadText();
    checkAll("R3");
  endtask

  task automatic t_noWrite();
    doWord("R4", mkCw(3'd5, 3'd1, 3'd2, 1'b0, 4'b0010, 1'b1, 1'b0), 8'h55, 8'hAA);
    doWord("R4", mkCw(3'd0, 3'd3, 3'd4, 1'b1, 4'b1100, 1'b0, 1'b0), 8'h11, 8'h22);
    checkAll("R4");
  endtask

  task automatic t_selects();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      ctrlWord = mkCw(3'd0, 3'(k), 3'(7 - k), 1'b0, 4'b0000, 1'b0, 1'b0);
      #1;
      chk("R1", "addrOut", addrOut, model[k]);
      chk("R1", "dataOut", dataOut, model[7 - k]);
    end
  endtask

  task automatic t_const();
    logic [W-1:0] v;
    doWord("R2", mkCw(3'd6, 3'd0, 3'd3, 1'b1, 4'b1100, 1'b0, 1'b1), 8'h3C, 8'h00);
    readReg(3'd6, v);
    chk("R2", "R6 from constant", v, 8'h3C);
    doWord("R2", mkCw(3'd5, 3'd1, 3'd2, 1'b1, 4'b0010, 1'b0, 1'b1), 8'h05, 8'h00);
    readReg(3'd5, v);
    chk("R2", "R5 = R1 + const", v, model[5]);
  endtask

  task automatic t_functions();
    logic [W-1:0] pa [4];
    logic [W-1:0] pb [4];
    logic [W-1:0] v;
    logic [W+3:0] r;
    pa[0] = 8'h7F; pb[0] = 8'h01;
    pa[1] = 8'h80; pb[1] = 8'hFF;
    pa[2] = 8'h00; pb[2] = 8'h00;
    pa[3] = 8'hA5; pb[3] = 8'h3C;
    for (int p = 0; p < 4; p++) begin
      doWord("R3", mkCw(3'd1, 3'd0, 3'd0, 1'b0, 4'b0000, 1'b1, 1'b1), 8'h00, pa[p]);
      doWord("R3", mkCw(3'd2, 3'd0, 3'd0, 1'b0, 4'b0000, 1'b1, 1'b1), 8'h00, pb[p]);
      for (int fs = 0; fs < 16; fs++) begin
        r = refFn(4'(fs), pa[p], pb[p]);
        doWord(fnReq(4'(fs)), mkCw(3'd7, 3'd1, 3'd2, 1'b0, 4'(fs), 1'b0, 1'b1), 8'h00, 8'h00);
        readReg(3'd7, v);
        chk(fnReq(4'(fs)), $sformatf("fn %0d result", fs), v, r[W-1:0]);
      end
    end
  endtask

  task automatic t_readDuringWrite();
    logic [W-1:0] old;
    logic [W-1:0] v;
    old = model[3];
    @(negedge clk);
    ctrlWord = mkCw(3'd3, 3'd3, 3'd3, 1'b0, 4'b0001, 1'b0, 1'b1);
    #1;
    chk("R6", "old value on A bus", addrOut, old);
    chk("R6", "old value on B bus", dataOut, old);
    @(posedge clk);
    model[3] = old + 8'd1;
    readReg(3'd3, v);
    chk("R6", "value after write", v, W'(old + 8'd1));
  endtask

  task automatic t_sequence();
    loadText();
    doWord("R11", mkCw(3'd0, 3'd1, 3'd2, 1'b0, 4'b0010, 1'b0, 1'b1), 8'h00, 8'h00);
    doWord("R11", mkCw(3'd2, 3'd0, 3'd4, 1'b0, 4'b1010, 1'b0, 1'b1), 8'h00, 8'h00);
    doWord("R11", mkCw(3'd4, 3'd0, 3'd5, 1'b0, 4'b1110, 1'b0, 1'b1), 8'h00, 8'h00);
    doWord("R11", mkCw(3'd5, 3'd6, 3'd7, 1'b0, 4'b0101, 1'b0, 1'b1), 8'h00, 8'h00);
    doWord("R11", mkCw(3'd6, 3'd6, 3'd0, 1'b1, 4'b0011, 1'b0, 1'b1), 8'h20, 8'h00);
    doWord("R11", mkCw(3'd7, 3'd3, 3'd7, 1'b0, 4'b1101, 1'b0, 1'b1), 8'h00, 8'h00);
    doWord("R11", mkCw(3'd1, 3'd1, 3'd0, 1'b0, 4'b1011, 1'b0, 1'b1), 8'h00, 8'h00);
    doWord("R11", mkCw(3'd3, 3'd3, 3'd3, 1'b0, 4'b0110, 1'b0, 1'b1), 8'h00, 8'h00);
    checkAll("R11");
  endtask

  task automatic t_resetMid();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    for (int k = 0; k < 8; k++) model[k] = '0;
    checkAll("R5");
  endtask

  initial begin
    text[0] = "D"; text[1] = "i"; text[2] = "g"; text[3] = "i";
    text[4] = "t"; text[5] = "a"; text[6] = "l"; text[7] = "!";
    t_reset();
    t_load();
    t_noWrite();
    t_selects();
    t_const();
    t_functions();
    t_readDuringWrite();
    t_sequence();
    t_resetMid();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule